// File: doc/BRIEF.md
# Set-Dueling Inclusion Policy Selector

This block decides at run time whether a shared last-level cache should behave exclusively or non-inclusively. A small number of set indices are reserved as sampling sets. Half of them always act exclusively and half always act non-inclusively. Every other index is a follower set, and follower sets take whichever policy won the most recent contest. For each cache access, the block gives a role and an effective policy bit. The data-flow controller uses these to decide whether incoming fills go into the last-level cache and whether clean upper-level victims are installed.

During an epoch, the selector counts three things in the sampling sets: misses in the exclusive group, misses in the non-inclusive group, and insertions in the non-inclusive group. It also accumulates retired instructions. When the instruction total reaches the epoch length, it makes its decision in one cycle. Exclusive mode wins only if it removes more than a threshold percentage of the non-inclusive misses. A second flag permits an aggressive non-inclusive fill policy when the estimated non-inclusive insertion rate is low. When the per-core variant is selected, each core owns its own sampling sets, counters and mode bit.

Top module: `incl_policy_sel`

## Requirements
- R1: `acc_role` is combinational from `acc_set`. It is 1 (exclusive sample) when the low `SAMPLE_SHIFT` bits are zero and bit `SAMPLE_SHIFT` is 0. It is 2 (non-inclusive sample) when the low bits are zero and that bit is 1. It is 0 (follower) in all other cases.
- R2: `acc_excl` is 1 for role 1 and 0 for role 2. For role 0 it equals `mode_excl[acc_core]`.
- R3: With `PER_CORE`=1, the owner core of a sample set is given by the `CORE_W` bits starting at bit `SAMPLE_SHIFT+1`. An event is counted only when `acc_core` equals that owner.
- R4: A valid counted access adds one to its group's miss counter when `acc_miss` is set. It adds one to the non-inclusive insertion counter when `acc_insert` is set in a role-2 set. Insertions in role-1 sets are not counted.
- R5: Retired instructions accumulate from `ret_count`. `epoch_tick` is high in any cycle where the running total plus `ret_count` is at least `EPOCH_INSTR`.
- R6: At an epoch edge, a bank selects exclusive when its non-inclusive misses N exceed its exclusive misses E and (N−E)·100 > `THRESH_PCT`·N. Otherwise it selects non-inclusive.
- R7: The event counters saturate at 2^`CNT_W`−1 and do not wrap.
- R8: At an epoch edge, all counters and the instruction total go to zero. Events presented in the epoch cycle itself are discarded.
- R9: At an epoch edge, `agg_en` of a bank is set only when non-inclusive is chosen and I·2^(`SAMPLE_SHIFT`+1)·banks·1000 < `AGG_IPKI`·`EPOCH_INSTR`, where I is the non-inclusive insertion count.
- R10: After reset, every `mode_excl` and `agg_en` bit is 0.
- R11: `mode_excl` and `agg_en` change only at epoch edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_set | input | SET_W | Set index of the access |
| acc_core | input | CORE_W | Core that issued the access |
| acc_miss | input | 1 | The access missed |
| acc_insert | input | 1 | The access inserted a line |
| ret_count | input | RET_W | Instructions retired this cycle |
| acc_role | output | 2 | Role of `acc_set` (0 follower, 1 exclusive sample, 2 non-inclusive sample) |
| acc_excl | output | 1 | Effective policy for this access (1 = exclusive) |
| epoch_tick | output | 1 | This cycle closes the epoch |
| mode_excl | output | NCORES | Selected mode per core (1 = exclusive) |
| agg_en | output | NCORES | Aggressive non-inclusive fill allowed per core |

## Verification
The assertions assume that `EPOCH_INSTR` is larger than the largest `ret_count` value, so two epoch edges can never fall on consecutive cycles. They also assume that reset is held until the clock runs. The stimulus retires at most three instructions per cycle against an epoch of thousands. It drives sample sets and follower sets for both cores, including accesses from one core into sets owned by the other. It reaches the counter limit only through counted misses between epoch edges.

// File: rtl/ips_pkg.sv
`timescale 1ns/1ps
package ips_pkg;
  typedef enum logic [1:0] {
    ROLE_FOLLOW = 2'd0,
    ROLE_EXCL   = 2'd1,
    ROLE_NINCL  = 2'd2
  } role_e;

  localparam int CNT_EM = 0;
  localparam int CNT_NM = 1;
  localparam int CNT_NI = 2;
  localparam int NUM_CNT = 3;
endpackage

// File: rtl/ips_set_classifier.sv
`timescale 1ns/1ps
module ips_set_classifier
  import ips_pkg::*;
#(
  parameter int SET_W        = 10,
  parameter int SAMPLE_SHIFT = 5,
  parameter int OWNER_W      = 1,
  parameter bit PER_CORE     = 1'b1
) (
  input  logic [SET_W-1:0]   set_idx,
  output role_e              role,
  output logic [OWNER_W-1:0] owner
);
  localparam int USED_W = SAMPLE_SHIFT + 1 + (PER_CORE ? OWNER_W : 0);

  logic sampled;

  // every 2**SAMPLE_SHIFT-th set is a sample set: wide NOR on low bits
  assign sampled = ~|set_idx[SAMPLE_SHIFT-1:0];

  always_comb begin
    if (!sampled)                    role = ROLE_FOLLOW;
    else if (set_idx[SAMPLE_SHIFT])  role = ROLE_NINCL;
    else                             role = ROLE_EXCL;
  end

  generate
    if (PER_CORE) begin : g_owner
      assign owner = set_idx[SAMPLE_SHIFT+1 +: OWNER_W];
    end else begin : g_single
      assign owner = '0;
    end
    if (SET_W > USED_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^set_idx[SET_W-1:USED_W];
    end
  endgenerate
endmodule

// File: rtl/ips_sat_counter.sv
`timescale 1ns/1ps
module ips_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = clr | inc;
    if (clr)                    q_d = '0;
    else if (inc && (q != '1))  q_d = q + W'(1);
    else                        q_d = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (q == '1 && !clr) |=> (q == '1));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
endmodule

// File: rtl/ips_decide_bank.sv
`timescale 1ns/1ps
module ips_decide_bank
  import ips_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int THRESH_PCT  = 5,
  parameter int AGG_IPKI    = 20,
  parameter int EPOCH_INSTR = 1000,
  parameter int SCALE       = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic epoch,
  input  logic inc_em,
  input  logic inc_nm,
  input  logic inc_ni,
  output logic mode_excl,
  output logic agg_en
);
  localparam int PW = CNT_W + 16;
  localparam logic [63:0] AGG_LIMIT = 64'(AGG_IPKI) * 64'(EPOCH_INSTR);

  logic [NUM_CNT-1:0] inc_vec;
  logic [CNT_W-1:0]   cnt [NUM_CNT];
  logic [PW-1:0]      gain, lhs, rhs;
  logic [63:0]        ins_scaled;
  logic               excl_win, agg_low;
  logic               mode_d, agg_d;

  assign inc_vec[CNT_EM] = inc_em & ~epoch;
  assign inc_vec[CNT_NM] = inc_nm & ~epoch;
  assign inc_vec[CNT_NI] = inc_ni & ~epoch;

  generate
    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      ips_sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (epoch),
        .inc   (inc_vec[k]),
        .q     (cnt[k])
      );
    end
  endgenerate

  // comparator: exclusive must remove more than THRESH_PCT % of misses
  always_comb begin
    gain = (cnt[CNT_NM] > cnt[CNT_EM]) ? PW'(cnt[CNT_NM] - cnt[CNT_EM]) : '0;
    lhs  = gain * PW'(100);
    rhs  = PW'(THRESH_PCT) * PW'(cnt[CNT_NM]);
    excl_win   = (cnt[CNT_NM] > cnt[CNT_EM]) && (lhs > rhs);
    ins_scaled = 64'(cnt[CNT_NI]) * 64'(SCALE) * 64'(1000);
    agg_low    = ins_scaled < AGG_LIMIT;
    mode_d     = excl_win;
    agg_d      = !excl_win && agg_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_excl <= 1'b0;
      agg_en    <= 1'b0;
    end else if (epoch) begin
      mode_excl <= mode_d;
      agg_en    <= agg_d;
    end
  end

  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch |=> ($stable(mode_excl) && $stable(agg_en)));
  p_agg_nincl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    agg_en |-> !mode_excl);
endmodule

// File: rtl/incl_policy_sel.sv
`timescale 1ns/1ps
module incl_policy_sel
  import ips_pkg::*;
#(
  parameter int SET_W        = 10,
  parameter int SAMPLE_SHIFT = 5,
  parameter int NCORES       = 2,
  parameter bit PER_CORE     = 1'b1,
  parameter int RET_W        = 2,
  parameter int CNT_W        = 16,
  parameter int EPOCH_INSTR  = 1000,
  parameter int THRESH_PCT   = 5,
  parameter int AGG_IPKI     = 20,
  localparam int CORE_W      = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [SET_W-1:0]  acc_set,
  input  logic [CORE_W-1:0] acc_core,
  input  logic              acc_miss,
  input  logic              acc_insert,
  input  logic [RET_W-1:0]  ret_count,
  output logic [1:0]        acc_role,
  output logic              acc_excl,
  output logic              epoch_tick,
  output logic [NCORES-1:0] mode_excl,
  output logic [NCORES-1:0] agg_en
);
  localparam int NBANK = PER_CORE ? NCORES : 1;
  localparam int SCALE = (2 ** (SAMPLE_SHIFT + 1)) * NBANK;
  localparam int IW    = $clog2(EPOCH_INSTR + (2 ** RET_W)) + 1;

  role_e             role;
  logic [CORE_W-1:0] owner;
  logic [NBANK-1:0]  bank_hit, bank_mode, bank_agg;
  logic [IW-1:0]     instr_q, instr_d, instr_sum;
  logic              epoch;

  ips_set_classifier #(
    .SET_W(SET_W), .SAMPLE_SHIFT(SAMPLE_SHIFT),
    .OWNER_W(CORE_W), .PER_CORE(PER_CORE)
  ) u_class (
    .set_idx (acc_set),
    .role    (role),
    .owner   (owner)
  );

  // epoch counter in retired instructions; remainder dropped at the edge
  always_comb begin
    instr_sum = instr_q + IW'(ret_count);
    epoch     = instr_sum >= IW'(EPOCH_INSTR);
    instr_d   = epoch ? '0 : instr_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) instr_q <= '0;
    else        instr_q <= instr_d;
  end

  assign epoch_tick = epoch;

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      if (PER_CORE) begin : g_pc
        assign bank_hit[b] = acc_valid && (role != ROLE_FOLLOW) &&
                             (owner == CORE_W'(b)) && (acc_core == owner);
      end else begin : g_sh
        assign bank_hit[b] = acc_valid && (role != ROLE_FOLLOW);
      end
      ips_decide_bank #(
        .CNT_W(CNT_W), .THRESH_PCT(THRESH_PCT), .AGG_IPKI(AGG_IPKI),
        .EPOCH_INSTR(EPOCH_INSTR), .SCALE(SCALE)
      ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .epoch     (epoch),
        .inc_em    (bank_hit[b] && (role == ROLE_EXCL) && acc_miss),
        .inc_nm    (bank_hit[b] && (role == ROLE_NINCL) && acc_miss),
        .inc_ni    (bank_hit[b] && (role == ROLE_NINCL) && acc_insert),
        .mode_excl (bank_mode[b]),
        .agg_en    (bank_agg[b])
      );
    end
    for (genvar c = 0; c < NCORES; c++) begin : g_fan
      if (PER_CORE) begin : g_own
        assign mode_excl[c] = bank_mode[c];
        assign agg_en[c]    = bank_agg[c];
      end else begin : g_all
        assign mode_excl[c] = bank_mode[0];
        assign agg_en[c]    = bank_agg[0];
      end
    end
  endgenerate

  always_comb begin
    acc_role = role;
    unique case (role)
      ROLE_EXCL:  acc_excl = 1'b1;
      ROLE_NINCL: acc_excl = 1'b0;
      default:    acc_excl = (32'(acc_core) < NCORES) ? mode_excl[acc_core] : 1'b0;
    endcase
  end

  p_epoch_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    epoch |=> !epoch);
  p_sample_role_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_set[SAMPLE_SHIFT-1:0] != '0) |-> (acc_role == 2'd0));
endmodule

// File: tb/incl_policy_sel_tb.sv
`timescale 1ns/1ps
module incl_policy_sel_tb;
  localparam int EPOCH = 20000;
  localparam int CW    = 8;
  localparam int SATV  = (1 << CW) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic [9:0] acc_set = '0;
  logic [0:0] acc_core = '0;
  logic       acc_miss = 1'b0, acc_insert = 1'b0;
  logic [1:0] ret_count = '0;
  logic [1:0] acc_role;
  logic       acc_excl, epoch_tick;
  logic [1:0] mode_excl, agg_en;

  int tests = 0, fails = 0;
  bit done = 0;

  // reference model state
  int em[2], nm[2], ni[2];
  int instr = 0;
  bit mdl_mode[2], mdl_agg[2];

  always #2.5 clk = ~clk;

  incl_policy_sel #(.EPOCH_INSTR(EPOCH), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_core(acc_core), .acc_miss(acc_miss), .acc_insert(acc_insert),
    .ret_count(ret_count), .acc_role(acc_role), .acc_excl(acc_excl),
    .epoch_tick(epoch_tick), .mode_excl(mode_excl), .agg_en(agg_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] mkset(input int hi, input bit core, input bit grp);
    return {hi[2:0], core, grp, 5'b00000};
  endfunction

  task automatic step(input bit v, input logic [9:0] s, input bit c,
                      input bit m, input bit ins, input int r);
    int role_x, owner, excl_x, sum;
    bit tick;
    @(negedge clk);
    acc_valid = v; acc_set = s; acc_core = c; acc_miss = m; acc_insert = ins;
    ret_count = 2'(r);
    #1;
    role_x = (s[4:0] != 0) ? 0 : (s[5] ? 2 : 1);
    owner  = s[6];
    excl_x = (role_x == 1) ? 1 : (role_x == 2) ? 0 : int'(mdl_mode[c]);
    sum    = instr + r;
    tick   = sum >= EPOCH;
    chk(acc_role == 2'(role_x), "R1 role", acc_role, role_x);
    chk(acc_excl == excl_x[0], "R2 acc_excl", acc_excl, excl_x);
    chk(epoch_tick == tick, "R5 epoch_tick", epoch_tick, tick);
    for (int k = 0; k < 2; k++) begin
      chk(mode_excl[k] == mdl_mode[k], "R11 mode hold/update", mode_excl[k], mdl_mode[k]);
      chk(agg_en[k] == mdl_agg[k], "R9 agg", agg_en[k], mdl_agg[k]);
    end
    // model update at the coming edge
    if (tick) begin
      for (int k = 0; k < 2; k++) begin
        bit win;
        win = (nm[k] > em[k]) && ((nm[k] - em[k]) * 100 > 5 * nm[k]);
        mdl_mode[k] = win;
        mdl_agg[k]  = !win && (longint'(ni[k]) * 128 * 1000 < longint'(20) * EPOCH);
        em[k] = 0; nm[k] = 0; ni[k] = 0;
      end
      instr = 0;
    end else begin
      instr = sum;
      if (v && role_x != 0 && c == owner[0]) begin
        if (role_x == 1 && m)   em[owner] = (em[owner] < SATV) ? em[owner] + 1 : SATV;
        if (role_x == 2 && m)   nm[owner] = (nm[owner] < SATV) ? nm[owner] + 1 : SATV;
        if (role_x == 2 && ins) ni[owner] = (ni[owner] < SATV) ? ni[owner] + 1 : SATV;
      end
    end
  endtask

  task automatic burst(input bit owner, input bit grp, input bit src,
                       input bit m, input bit ins, input int n);
    for (int k = 0; k < n; k++) step(1, mkset(k, owner, grp), src, m, ins, 0);
  endtask

  // retire until the epoch closes; the closing cycle carries the given event
  task automatic close_epoch(input bit v, input logic [9:0] s, input bit c, input bit m);
    while (instr + 3 < EPOCH) step(0, 10'h001, 0, 0, 0, 3);
    step(v, s, c, m, 0, 3);
  endtask

  task automatic expect_modes(input bit m0, input bit a0, input bit m1, input bit a1,
                              input string tag);
    @(posedge clk); #1;
    chk(mode_excl[0] == m0, {tag, " mode core0"}, mode_excl[0], m0);
    chk(agg_en[0] == a0,    {tag, " agg core0"},  agg_en[0], a0);
    chk(mode_excl[1] == m1, {tag, " mode core1"}, mode_excl[1], m1);
    chk(agg_en[1] == a1,    {tag, " agg core1"},  agg_en[1], a1);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired, actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk(mode_excl == 2'b00, "R10 reset mode", mode_excl, 0);
    chk(agg_en == 2'b00, "R10 reset agg", agg_en, 0);
    @(negedge clk); rst_n = 1'b1;

    // E1: R4/R6 core0 10 vs 20 misses -> exclusive; core1 4 inserts -> no agg (R9)
    burst(0, 0, 0, 1, 0, 10);
    burst(0, 1, 0, 1, 0, 20);
    burst(1, 1, 1, 0, 1, 4);
    burst(0, 0, 0, 0, 1, 6);   // R4: insertions in exclusive samples not counted
    for (int k = 0; k < 20; k++) step(1, 10'h003 + 10'(k << 5), k % 2, 1, 1, 1); // followers
    close_epoch(0, 10'h001, 0, 0);
    expect_modes(1, 0, 0, 0, "R6 E1");

    // E2: threshold boundary (R6) and agg at 3 insertions (R9); mode held (R11)
    burst(0, 0, 0, 1, 0, 19);
    burst(0, 1, 0, 1, 0, 20);
    burst(1, 0, 1, 1, 0, 18);
    burst(1, 1, 1, 1, 0, 20);
    burst(0, 1, 0, 0, 1, 3);
    close_epoch(0, 10'h001, 0, 0);
    expect_modes(0, 1, 1, 0, "R6 R9 E2");

    // E3: R7 saturation: 240 vs 300 (saturates to 255) -> exclusive
    burst(0, 0, 0, 1, 0, 240);
    burst(0, 1, 0, 1, 0, 300);
    close_epoch(0, 10'h001, 0, 0);
    expect_modes(1, 0, 0, 1, "R7 E3");

    // E4: R3 foreign-core events into core0 samples are ignored
    burst(0, 0, 0, 1, 0, 5);
    burst(0, 1, 0, 1, 0, 10);
    burst(0, 0, 1, 1, 0, 50);
    burst(1, 1, 0, 1, 1, 30);
    close_epoch(0, 10'h001, 0, 0);
    expect_modes(1, 0, 0, 1, "R3 E4");

    // E5: R8 event in the closing cycle is discarded (18 vs 20 stays exclusive)
    burst(0, 0, 0, 1, 0, 18);
    burst(0, 1, 0, 1, 0, 20);
    close_epoch(1, mkset(0, 0, 0), 0, 1);
    expect_modes(1, 0, 0, 1, "R8 E5");

    // mixed random traffic, compared cycle by cycle
    for (int k = 0; k < 40000; k++) begin
      logic [9:0] s;
      s = 10'($urandom);
      if ($urandom % 2 == 0) s[4:0] = '0;
      step($urandom % 2, s, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 4);
    end

    done = 1;
    finish_run();
  end
endmodule